// File: doc/BRIEF.md
# Cyclic Partition Time-Slot Scheduler

This block shares one execution resource among several tasks by cutting time into a repeating major frame of slots. A table gives each slot a length in ticks and an owning task. The scheduler walks the slots in index order and returns to slot 0 after the last one. Within a slot, only the owner may be granted the resource, and only while it has work left. A task whose work outlasts its slot is stopped at the boundary and resumes in its next slot. It never runs into a neighbour's slot, even when that neighbour is idle.

Software loads a per-task remaining-work count through a small write port. Each granted tick consumes one unit of that count. A second write port fills a shadow copy of the slot table, and the shadow is adopted only when a new major frame begins, so a frame never runs on a half-written table. When the owner changes between slots, a fixed context-switch interval is held at the start of the new slot. The block signals each slot boundary with a one-cycle interrupt and raises a per-task overrun flag when a task is cut off with work remaining.

Top module: `slot_sched`

## Requirements
- R1: After reset, slotIdx is 0, grantValid, slotIrq and every overrun bit are 0, and the table holds slot i with length DEF_LEN (4) and owner i mod NUM_TASKS.
- R2: Time advances only on cycles with tick high. Slot i lasts max(length_i, 1) ticks, and slots run in order 0, 1, … NUM_SLOTS-1, then 0.
- R3: slotIrq is high for exactly the one cycle that follows the tick ending a slot. It is low after any cycle with tick low.
- R4: grantTask is the owner of the current slot. Only that task is granted, and the granted task never changes within a slot.
- R5: The first CTX_TICKS (1) ticks of a slot grant nothing when its owner differs from the owner of the slot just ended, and also in the first slot after reset. Otherwise the gap is absent.
- R6: A write with workWe sets the task's remaining work to workAmt. Each tick on which the task is granted decreases it by one. A task with zero remaining work is not granted, and its slot stays idle.
- R7: A task's overrun bit (bit index = task ID) is set when its slot ends with work remaining. It clears when its remaining work is decremented to zero.
- R8: Table writes (tblWe with tblIdx, tblLen, tblTask) go to a shadow copy. They take effect only when slot 0 of the next major frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Scheduler timebase; one tick per high cycle |
| tblWe | input | 1 | Write strobe for the shadow slot table |
| tblIdx | input | SLOT_W | Slot entry to write |
| tblLen | input | LEN_W | Slot length in ticks (0 acts as 1) |
| tblTask | input | TASK_W | Owning task of the slot |
| workWe | input | 1 | Load strobe for a task's remaining work |
| workTask | input | TASK_W | Task whose work is loaded |
| workAmt | input | WORK_W | New remaining-work count |
| slotIdx | output | SLOT_W | Current slot index |
| grantValid | output | 1 | Resource granted this cycle |
| grantTask | output | TASK_W | Granted task (0 when no grant) |
| slotIrq | output | 1 | One-cycle pulse after a slot boundary |
| overrun | output | NUM_TASKS | Per-task overrun flags |

## Verification
The bound checker watches, on every cycle, that the slot index stays in range and freezes without a tick. It also checks that the boundary pulse never follows an idle cycle, that the grant never switches task inside a slot, and that no grant is given in the first cycle of a slot entered with an owner change. Further per-cycle checks confirm that overrun bits only rise together with a boundary pulse and that the active slot length and owner stay fixed until the slot changes. The exact number of granted ticks per slot is shown only by the bench's directed scenarios. So are the suspension of unfinished work until the owner's next slot, the idle slot beside a task with pending work, the deferred adoption of a rewritten table, and the clearing of an overrun flag on completion.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  typedef struct packed {
    logic endSlot;  // tick that closes the current slot
    logic wrap;     // slot boundary that also closes the major frame
    logic grant;    // tick on which the owner consumes one unit of work
  } ctlStrobe_t;
endpackage

// File: rtl/slot_sched_ctrl.sv
module slot_sched_ctrl
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int LEN_W     = 8,
  parameter int CTX_TICKS = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [LEN_W-1:0]    curLen,
  input  logic                ownerChange,
  input  logic                ownerBusy,
  output logic [(NUM_SLOTS>1 ? $clog2(NUM_SLOTS) : 1)-1:0] slotIdx,
  output logic                grantValid,
  output logic                slotIrq,
  output ctlStrobe_t          strb
);
  localparam int SLOT_W = NUM_SLOTS > 1 ? $clog2(NUM_SLOTS) : 1;
  localparam int CTX_W  = $clog2(CTX_TICKS + 2);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [CTX_W-1:0]  CTX_LOAD  = CTX_W'(CTX_TICKS);

  logic [LEN_W-1:0] tickCnt;
  logic [CTX_W-1:0] ctxLeft;
  logic             lastTick;

  // A length of zero compares as a one-tick slot.
  assign lastTick   = ({1'b0, tickCnt} + 1'b1) >= {1'b0, curLen};
  assign grantValid = ownerBusy && (ctxLeft == '0);

  always_comb begin
    strb.endSlot = tick && lastTick;
    strb.wrap    = tick && lastTick && (slotIdx == LAST_SLOT);
    strb.grant   = tick && grantValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotIdx <= '0;
      tickCnt <= '0;
      ctxLeft <= CTX_LOAD;
      slotIrq <= 1'b0;
    end else begin
      slotIrq <= strb.endSlot;
      if (tick) begin
        if (lastTick) begin
          tickCnt <= '0;
          slotIdx <= (slotIdx == LAST_SLOT) ? '0 : slotIdx + 1'b1;
          ctxLeft <= ownerChange ? CTX_LOAD : '0;
        end else begin
          tickCnt <= tickCnt + 1'b1;
          if (ctxLeft != '0) ctxLeft <= ctxLeft - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/slot_sched_dp.sv
module slot_sched_dp
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_TASKS = 4,
  parameter int LEN_W     = 8,
  parameter int WORK_W    = 8,
  parameter int DEF_LEN   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strb,
  input  logic [(NUM_SLOTS>1 ? $clog2(NUM_SLOTS) : 1)-1:0] slotIdx,
  input  logic                tblWe,
  input  logic [(NUM_SLOTS>1 ? $clog2(NUM_SLOTS) : 1)-1:0] tblIdx,
  input  logic [LEN_W-1:0]    tblLen,
  input  logic [(NUM_TASKS>1 ? $clog2(NUM_TASKS) : 1)-1:0] tblTask,
  input  logic                workWe,
  input  logic [(NUM_TASKS>1 ? $clog2(NUM_TASKS) : 1)-1:0] workTask,
  input  logic [WORK_W-1:0]   workAmt,
  output logic [LEN_W-1:0]    curLen,
  output logic [(NUM_TASKS>1 ? $clog2(NUM_TASKS) : 1)-1:0] curOwner,
  output logic                ownerChange,
  output logic                ownerBusy,
  output logic [NUM_TASKS-1:0] overrun
);
  localparam int SLOT_W = NUM_SLOTS > 1 ? $clog2(NUM_SLOTS) : 1;
  localparam int TASK_W = NUM_TASKS > 1 ? $clog2(NUM_TASKS) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [LEN_W-1:0]  shLen  [NUM_SLOTS];
  logic [TASK_W-1:0] shTask [NUM_SLOTS];
  logic [LEN_W-1:0]  actLen [NUM_SLOTS];
  logic [TASK_W-1:0] actTask[NUM_SLOTS];
  logic [WORK_W-1:0] workCnt [NUM_TASKS];
  logic [WORK_W-1:0] workNext[NUM_TASKS];
  logic [SLOT_W-1:0] nextIdx;
  logic [TASK_W-1:0] nextOwner;

  // Shadow and active slot tables; the shadow is adopted at frame wrap.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        shLen[s]   <= LEN_W'(DEF_LEN);
        shTask[s]  <= TASK_W'(s % NUM_TASKS);
        actLen[s]  <= LEN_W'(DEF_LEN);
        actTask[s] <= TASK_W'(s % NUM_TASKS);
      end
    end else begin
      if (tblWe && (int'(tblIdx) < NUM_SLOTS)) begin
        shLen[tblIdx]  <= tblLen;
        shTask[tblIdx] <= tblTask;
      end
      if (strb.wrap) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          actLen[s]  <= shLen[s];
          actTask[s] <= shTask[s];
        end
      end
    end
  end

  assign curLen      = actLen[slotIdx];
  assign curOwner    = actTask[slotIdx];
  assign nextIdx     = (slotIdx == LAST_SLOT) ? '0 : slotIdx + 1'b1;
  assign nextOwner   = (slotIdx == LAST_SLOT) ? shTask[0] : actTask[nextIdx];
  assign ownerChange = nextOwner != curOwner;

  always_comb begin
    ownerBusy = 1'b0;
    for (int t = 0; t < NUM_TASKS; t++)
      if (curOwner == TASK_W'(t)) ownerBusy = workCnt[t] != '0;
  end

  // Per-task remaining work and overrun flag.
  for (genvar t = 0; t < NUM_TASKS; t++) begin : gTask
    logic isOwner, isLoad, doDec;
    assign isOwner = curOwner == TASK_W'(t);
    assign isLoad  = workWe && (workTask == TASK_W'(t));
    assign doDec   = strb.grant && isOwner;

    always_comb begin
      workNext[t] = workCnt[t];
      if (doDec) workNext[t] = workCnt[t] - 1'b1;
      if (isLoad) workNext[t] = workAmt;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        workCnt[t] <= '0;
        overrun[t] <= 1'b0;
      end else begin
        workCnt[t] <= workNext[t];
        if (doDec && !isLoad && workCnt[t] == WORK_W'(1))
          overrun[t] <= 1'b0;
        else if (strb.endSlot && isOwner && workNext[t] != '0)
          overrun[t] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_TASKS = 4,
  parameter int LEN_W     = 8,
  parameter int WORK_W    = 8,
  parameter int DEF_LEN   = 4,
  parameter int CTX_TICKS = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                tblWe,
  input  logic [(NUM_SLOTS>1 ? $clog2(NUM_SLOTS) : 1)-1:0] tblIdx,
  input  logic [LEN_W-1:0]    tblLen,
  input  logic [(NUM_TASKS>1 ? $clog2(NUM_TASKS) : 1)-1:0] tblTask,
  input  logic                workWe,
  input  logic [(NUM_TASKS>1 ? $clog2(NUM_TASKS) : 1)-1:0] workTask,
  input  logic [WORK_W-1:0]   workAmt,
  output logic [(NUM_SLOTS>1 ? $clog2(NUM_SLOTS) : 1)-1:0] slotIdx,
  output logic                grantValid,
  output logic [(NUM_TASKS>1 ? $clog2(NUM_TASKS) : 1)-1:0] grantTask,
  output logic                slotIrq,
  output logic [NUM_TASKS-1:0] overrun
);
  localparam int TASK_W = NUM_TASKS > 1 ? $clog2(NUM_TASKS) : 1;

  ctlStrobe_t        strb;
  logic [LEN_W-1:0]  curLen;
  logic [TASK_W-1:0] curOwner;
  logic              ownerChange;
  logic              ownerBusy;

  slot_sched_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .LEN_W(LEN_W), .CTX_TICKS(CTX_TICKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .curLen(curLen),
    .ownerChange(ownerChange), .ownerBusy(ownerBusy),
    .slotIdx(slotIdx), .grantValid(grantValid), .slotIrq(slotIrq), .strb(strb)
  );

  slot_sched_dp #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_TASKS(NUM_TASKS), .LEN_W(LEN_W),
    .WORK_W(WORK_W), .DEF_LEN(DEF_LEN)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .slotIdx(slotIdx),
    .tblWe(tblWe), .tblIdx(tblIdx), .tblLen(tblLen), .tblTask(tblTask),
    .workWe(workWe), .workTask(workTask), .workAmt(workAmt),
    .curLen(curLen), .curOwner(curOwner), .ownerChange(ownerChange),
    .ownerBusy(ownerBusy), .overrun(overrun)
  );

  assign grantTask = grantValid ? curOwner : '0;
endmodule

// File: rtl/slot_sched_check.sv
module slot_sched_check #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_TASKS = 4,
  parameter int LEN_W     = 8,
  parameter int CTX_TICKS = 1
) (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic [(NUM_SLOTS>1 ? $clog2(NUM_SLOTS) : 1)-1:0] slotIdx,
  input logic slotIrq,
  input logic grantValid,
  input logic [(NUM_TASKS>1 ? $clog2(NUM_TASKS) : 1)-1:0] grantTask,
  input logic [NUM_TASKS-1:0] overrun,
  input logic [(NUM_TASKS>1 ? $clog2(NUM_TASKS) : 1)-1:0] curOwner,
  input logic [LEN_W-1:0] curLen
);
  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    int'(slotIdx) < NUM_SLOTS);

  assert_frozen_without_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(slotIdx));

  assert_irq_needs_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !slotIrq);

  assert_grant_steady_in_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && $past(grantValid) && slotIdx == $past(slotIdx)) |-> grantTask == $past(grantTask));

  assert_switch_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (CTX_TICKS > 0 && slotIrq && curOwner != $past(curOwner)) |-> !grantValid);

  assert_overrun_at_boundary_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(overrun & ~$past(overrun))) |-> slotIrq);

  assert_table_fixed_in_slot_R8: assert property (@(posedge clk) disable iff (!rstN)
    (NUM_SLOTS > 1 && $stable(slotIdx)) |-> ($stable(curLen) && $stable(curOwner)));
endmodule

bind slot_sched slot_sched_check #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_TASKS(NUM_TASKS), .LEN_W(LEN_W), .CTX_TICKS(CTX_TICKS)
) uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .slotIdx(slotIdx), .slotIrq(slotIrq),
  .grantValid(grantValid), .grantTask(grantTask), .overrun(overrun),
  .curOwner(curOwner), .curLen(curLen)
);

// File: tb/slot_sched_test.sv
module slot_sched_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       tblWe = 1'b0;
  logic [1:0] tblIdx = '0;
  logic [7:0] tblLen = '0;
  logic [1:0] tblTask = '0;
  logic       workWe = 1'b0;
  logic [1:0] workTask = '0;
  logic [7:0] workAmt = '0;
  logic [1:0] slotIdx;
  logic       grantValid;
  logic [1:0] grantTask;
  logic       slotIrq;
  logic [3:0] overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slot_sched uut (
    .clk(clk), .rstN(rstN), .tick(tick),
    .tblWe(tblWe), .tblIdx(tblIdx), .tblLen(tblLen), .tblTask(tblTask),
    .workWe(workWe), .workTask(workTask), .workAmt(workAmt),
    .slotIdx(slotIdx), .grantValid(grantValid), .grantTask(grantTask),
    .slotIrq(slotIrq), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Runs n ticks; counts sampled grants to task tsk and grants to anyone.
  task automatic runTicks(input int n, input int tsk, output int own, output int any);
    own = 0; any = 0;
    for (int i = 0; i < n; i++) begin
      if (grantValid) begin
        any++;
        if (int'(grantTask) == tsk) own++;
      end
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic loadWork(input int tsk, input int amt);
    workWe = 1'b1; workTask = 2'(tsk); workAmt = 8'(amt);
    @(negedge clk);
    workWe = 1'b0;
  endtask

  task automatic writeSlot(input int idx, input int len, input int tsk);
    tblWe = 1'b1; tblIdx = 2'(idx); tblLen = 8'(len); tblTask = 2'(tsk);
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic testReset();
    check(slotIdx == 0, "R1 slotIdx", slotIdx, 0);
    check(!grantValid, "R1 grantValid", grantValid, 0);
    check(!slotIrq, "R1 slotIrq", slotIrq, 0);
    check(overrun == 0, "R1 overrun", overrun, 0);
  endtask

  task automatic testNoTick();
    idle(5);
    check(slotIdx == 0, "R2 no tick keeps slot", slotIdx, 0);
    check(!slotIrq, "R3 no pulse without tick", slotIrq, 0);
  endtask

  task automatic testFirstSlot();
    int own, any;
    loadWork(0, 2);
    loadWork(1, 6);
    check(!grantValid, "R5 gap in first slot", grantValid, 0);
    runTicks(4, 0, own, any);
    check(own == 2, "R6 task0 grants", own, 2);
    check(slotIdx == 1, "R2 slot after 4 ticks", slotIdx, 1);
    check(slotIrq, "R3 boundary pulse", slotIrq, 1);
    check(overrun == 0, "R7 no overrun when done", overrun, 0);
    idle(1);
    check(!slotIrq, "R3 pulse one cycle", slotIrq, 0);
  endtask

  task automatic testOverrun();
    int own, any;
    check(!grantValid, "R5 gap after owner change", grantValid, 0);
    runTicks(4, 1, own, any);
    check(own == 3 && any == 3, "R4 task1 grants in slot1", own, 3);
    check(overrun == 4'b0010, "R7 overrun set for task1", overrun, 2);
    check(slotIdx == 2, "R2 slot2 reached", slotIdx, 2);
  endtask

  task automatic testFenced();
    int own, any;
    runTicks(8, 1, own, any);
    check(any == 0, "R4 no spill into idle slots", any, 0);
    check(slotIdx == 0, "R2 wrap to slot0", slotIdx, 0);
    check(overrun == 4'b0010, "R7 overrun held", overrun, 2);
  endtask

  task automatic testTableSwap();
    int own, any;
    writeSlot(2, 6, 1);
    loadWork(1, 20);
    runTicks(4, 1, own, any);
    check(any == 0, "R6 idle slot0 without work", any, 0);
    runTicks(4, 1, own, any);
    check(own == 3, "R6 task1 slot1 grants", own, 3);
    runTicks(4, 1, own, any);
    check(any == 0, "R8 old owner of slot2 kept", any, 0);
    check(slotIdx == 3, "R8 old length of slot2 kept", slotIdx, 3);
    runTicks(4, 1, own, any);
    check(slotIdx == 0, "R2 frame wrap", slotIdx, 0);
    runTicks(8, 1, own, any);
    check(own == 3, "R5 gap before task1 slot", own, 3);
    runTicks(6, 1, own, any);
    check(own == 6, "R5 no gap on same owner, R8 new table", own, 6);
    check(slotIdx == 3, "R8 new length six", slotIdx, 3);
    check(overrun == 4'b0010, "R7 overrun with 8 left", overrun, 2);
  endtask

  task automatic testCompletion();
    int own, any;
    runTicks(8, 1, own, any);
    runTicks(4, 1, own, any);
    check(own == 3, "R6 task1 resumes in own slot", own, 3);
    runTicks(6, 1, own, any);
    check(own == 5, "R6 stops at zero work", own, 5);
    check(overrun == 0, "R7 overrun cleared on completion", overrun, 0);
    check(!grantValid && slotIdx == 3, "R6 idle after completion", slotIdx, 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoTick();
    testFirstSlot();
    testOverrun();
    testFenced();
    testTableSwap();
    testCompletion();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule